// File: doc/BRIEF.md
# PHY Indirect Register Write Bridge

The bridge lets software write registers inside a serial-link PHY without a direct bus into the PHY. Software first loads a 32-bit payload into a data register. It then writes a command word. That word carries the PHY register address, a lane number, a rate select and a write-command bit. A 0-to-1 change of the write-command bit raises a request toward the PHY. A 1-to-0 change drops that request. The PHY answers each change with a matching change of its acknowledge line, so every access takes two phases: issue and clear.

The acknowledge line comes into the local clock domain through a synchroniser. It is reflected as a status bit in the command word, which software polls. While a phase waits for its acknowledge, further command writes are discarded. A hardware counter watches each waiting phase and raises a sticky timeout flag if the PHY stays silent for too long. A status word also shows the synchronised PHY-ready input, which software checks before link bring-up.

Top module: `phy_ind_bridge`

## Requirements
- R1: After reset, `phy_req_o` is 0, every PHY field output and `phy_wdata_o` is 0, and reads of offsets 0, 1, 2 and 3 return 0 while `phy_ready_i` is low.
- R2: The command word at offset 1 holds the PHY address in bits 7:0, the lane in bits 11:8, the rate select in bit 12 and the write-command bit in bit 16. An accepted write drives `phy_addr_o`, `phy_lane_o` and `phy_rate_o` from the cycle after the write. A read returns these fields in the same positions, with all other bits 0 apart from bit 24.
- R3: A write to offset 0 loads the data register. The data register drives `phy_wdata_o` and is returned by a read of offset 0 from the cycle after the write.
- R4: `phy_req_o` rises in the cycle after an accepted command write that sets bit 16 while the request is low. It falls in the cycle after an accepted command write that clears bit 16 while the request is high. It changes at no other time.
- R5: Bit 24 of the command word is `phy_ack_i` delayed by SYNC_STAGES clock edges. It is set once the PHY acknowledges a raised request and cleared once the PHY acknowledges a dropped request.
- R6: A phase is pending while the request differs from the synchronised acknowledge. A command write during a pending phase changes no field, no request and no readback.
- R7: When a phase stays pending for TIMEOUT_CYC consecutive cycles, bit 1 of the status word at offset 2 becomes 1 and stays set. Writing a 1 to bit 1 clears it, and writing a 0 has no effect. A new timeout in the same cycle as a clear wins over the clear.
- R8: Bit 0 of the status word is `phy_ready_i` delayed by SYNC_STAGES clock edges.
- R9: Offset 3 reads as 0, and writes to it change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write offset (0 data, 1 command, 2 status, 3 unmapped) |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read offset |
| reg_rdata | output | 32 | Read data for `reg_raddr`, combinational |
| phy_req_o | output | 1 | Write request to the PHY |
| phy_rate_o | output | 1 | Rate select for the access |
| phy_lane_o | output | 4 | Lane number for the access |
| phy_addr_o | output | 8 | PHY register address |
| phy_wdata_o | output | 32 | Payload to write |
| phy_ack_i | input | 1 | PHY acknowledge, asynchronous |
| phy_ready_i | input | 1 | PHY ready level, asynchronous |

## Verification
The bench fires a second command straight after an issue, while the acknowledge is still crossing the synchroniser. A bridge that treated an unacknowledged phase as finished would retarget the PHY in mid-access, and the address outputs would move. A silent PHY is held long enough to trip the timeout. A clear is then written while the stall persists, which exposes a clear that wins over a fresh timeout, and a flag that is not sticky would vanish on a zero write. The synchroniser depth is checked cycle by cycle against a behavioural model, so one stage too few or too many shows up on the acknowledge and ready bits.

// File: rtl/pib_pkg.sv
package pib_pkg;

  localparam int REG_W = 32;

  // register offsets on the software side
  typedef enum logic [1:0] {
    OFS_DATA = 2'd0,
    OFS_CMD  = 2'd1,
    OFS_STAT = 2'd2,
    OFS_NONE = 2'd3
  } reg_ofs_e;

  // command word bit positions (decoded by software, must stay fixed)
  localparam int ADDR_LSB = 0;
  localparam int LANE_LSB = 8;
  localparam int RATE_BIT = 12;
  localparam int WCMD_BIT = 16;
  localparam int ACK_BIT  = 24;

  // status word bit positions
  localparam int STAT_RDY_BIT = 0;
  localparam int STAT_ERR_BIT = 1;

  typedef struct packed {
    logic       wcmd;
    logic       rate;
    logic [3:0] lane;
    logic [7:0] addr;
  } phy_cmd_t;

  // assemble the command readback word
  function automatic logic [REG_W-1:0] cmd_readback(phy_cmd_t c, logic ack);
    logic [REG_W-1:0] w;
    w = '0;
    w[ADDR_LSB +: 8] = c.addr;
    w[LANE_LSB +: 4] = c.lane;
    w[RATE_BIT]      = c.rate;
    w[WCMD_BIT]      = c.wcmd;
    w[ACK_BIT]       = ack;
    return w;
  endfunction

  // assemble the status readback word
  function automatic logic [REG_W-1:0] stat_readback(logic rdy, logic err);
    logic [REG_W-1:0] w;
    w = '0;
    w[STAT_RDY_BIT] = rdy;
    w[STAT_ERR_BIT] = err;
    return w;
  endfunction

  // next value of the pending-phase cycle counter
  function automatic int unsigned wait_next(int unsigned cur, logic pending, logic hit);
    if (!pending)  return 0;
    else if (hit)  return cur;
    else           return cur + 1;
  endfunction

endpackage

// File: rtl/pib_sync.sv
module pib_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q <= '0;
        end else begin
          sh_q[0] <= d;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pib_regs.sv
module pib_regs
  import pib_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [1:0]       raddr,
  input  logic             busy,
  input  logic             ack_stat,
  input  logic             rdy_stat,
  input  logic             err_stat,
  output logic [REG_W-1:0] data_q,
  output phy_cmd_t         cmd_q,
  output logic             cmd_accept,
  output logic             err_clr,
  output logic [REG_W-1:0] rdata
);

  logic     cmd_wr;
  logic     data_wr;
  phy_cmd_t cmd_new;

  assign cmd_wr     = we && (waddr == OFS_CMD);
  assign data_wr    = we && (waddr == OFS_DATA);
  assign cmd_accept = cmd_wr && !busy;
  assign err_clr    = we && (waddr == OFS_STAT) && wdata[STAT_ERR_BIT];

  assign cmd_new.addr = wdata[ADDR_LSB +: 8];
  assign cmd_new.lane = wdata[LANE_LSB +: 4];
  assign cmd_new.rate = wdata[RATE_BIT];
  assign cmd_new.wcmd = wdata[WCMD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (data_wr)  data_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmd_q <= '0;
    else if (cmd_accept) cmd_q <= cmd_new;
  end

  always_comb begin
    unique case (raddr)
      OFS_DATA: rdata = data_q;
      OFS_CMD:  rdata = cmd_readback(cmd_q, ack_stat);
      OFS_STAT: rdata = stat_readback(rdy_stat, err_stat);
      default:  rdata = '0;
    endcase
  end

  // R6
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> $stable(cmd_q));

  // R2
  field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_accept |=> $stable(cmd_q));

endmodule

// File: rtl/pib_handshake.sv
module pib_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_accept,
  input  logic new_wcmd,
  input  logic ack_s,
  output logic req_q,
  output logic busy,
  output logic issue_evt,
  output logic drop_evt
);

  assign issue_evt = cmd_accept && new_wcmd && !req_q;
  assign drop_evt  = cmd_accept && !new_wcmd && req_q;
  assign busy      = req_q ^ ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_q <= 1'b0;
    else if (issue_evt) req_q <= 1'b1;
    else if (drop_evt)  req_q <= 1'b0;
  end

  // R4
  req_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != $past(req_q)) |-> $past(cmd_accept));

  // R4
  issue_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> req_q);

  // R4
  drop_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !req_q);

endmodule

// File: rtl/pib_timeout.sv
module pib_timeout
  import pib_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic err_clr,
  output logic err_q,
  output logic hit
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign hit   = busy && (cnt_q == LIM);
  assign cnt_d = CNT_W'(wait_next(int'(cnt_q), busy, hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (hit)          err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(busy));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  // R7
  idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (cnt_q == '0));

endmodule

// File: rtl/phy_ind_bridge.sv
module phy_ind_bridge
  import pib_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  output logic        phy_req_o,
  output logic        phy_rate_o,
  output logic [3:0]  phy_lane_o,
  output logic [7:0]  phy_addr_o,
  output logic [31:0] phy_wdata_o,
  input  logic        phy_ack_i,
  input  logic        phy_ready_i
);

  logic     ack_s, rdy_s;
  logic     busy, req_q, issue_evt, drop_evt;
  logic     cmd_accept, err_clr, err_q, tmo_hit;
  phy_cmd_t cmd_q;
  logic [REG_W-1:0] data_q;

  pib_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(phy_ack_i), .q(ack_s));

  pib_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(phy_ready_i), .q(rdy_s));

  pib_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata), .raddr(reg_raddr),
    .busy(busy), .ack_stat(ack_s), .rdy_stat(rdy_s), .err_stat(err_q),
    .data_q(data_q), .cmd_q(cmd_q), .cmd_accept(cmd_accept),
    .err_clr(err_clr), .rdata(reg_rdata));

  pib_handshake u_hs (
    .clk(clk), .rst_n(rst_n),
    .cmd_accept(cmd_accept), .new_wcmd(reg_wdata[WCMD_BIT]), .ack_s(ack_s),
    .req_q(req_q), .busy(busy), .issue_evt(issue_evt), .drop_evt(drop_evt));

  pib_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .busy(busy), .err_clr(err_clr),
    .err_q(err_q), .hit(tmo_hit));

  assign phy_req_o   = req_q;
  assign phy_rate_o  = cmd_q.rate;
  assign phy_lane_o  = cmd_q.lane;
  assign phy_addr_o  = cmd_q.addr;
  assign phy_wdata_o = data_q;

  // R4
  req_tracks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_evt || drop_evt) |=> (phy_req_o == cmd_q.wcmd));

  // R7
  hit_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> err_q);

endmodule

// File: tb/sim_phy_ind_bridge.sv
`timescale 1ns/1ps
module sim_phy_ind_bridge;

  localparam int SYNC = 2;
  localparam int TMO  = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_waddr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [1:0]  reg_raddr = 2'd0;
  logic [31:0] reg_rdata;
  logic        phy_req_o, phy_rate_o;
  logic [3:0]  phy_lane_o;
  logic [7:0]  phy_addr_o;
  logic [31:0] phy_wdata_o;
  logic        phy_ack_i = 1'b0;
  logic        phy_ready_i = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  phy_ind_bridge #(.SYNC_STAGES(SYNC), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .phy_req_o(phy_req_o), .phy_rate_o(phy_rate_o), .phy_lane_o(phy_lane_o),
    .phy_addr_o(phy_addr_o), .phy_wdata_o(phy_wdata_o),
    .phy_ack_i(phy_ack_i), .phy_ready_i(phy_ready_i));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // ---------------- behavioural reference model ----------------
  int unsigned m_data, m_addr, m_lane, m_rate, m_req, m_err, m_cnt;
  int unsigned ack_pipe[$];
  int unsigned rdy_pipe[$];

  function automatic int unsigned m_ack();
    return ack_pipe[SYNC-1];
  endfunction

  function automatic int unsigned m_rdy();
    return rdy_pipe[SYNC-1];
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] ofs);
    case (ofs)
      2'd0: return m_data;
      2'd1: return (m_ack() << 24) + (m_req << 16) + (m_rate << 12) + (m_lane << 8) + m_addr;
      2'd2: return (m_err * 2) + m_rdy();
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_reset();
    m_data = 0; m_addr = 0; m_lane = 0; m_rate = 0; m_req = 0; m_err = 0; m_cnt = 0;
    ack_pipe.delete(); rdy_pipe.delete();
    for (int i = 0; i < SYNC; i++) begin ack_pipe.push_back(0); rdy_pipe.push_back(0); end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (rst_n) begin
      bit pend, tmo, clr;
      pend = (m_req != m_ack());
      tmo  = pend && (m_cnt == TMO - 1);
      clr  = 1'b0;
      if (reg_we) begin
        case (reg_waddr)
          2'd0: m_data = reg_wdata;
          2'd1: if (!pend) begin
                  m_addr = reg_wdata[7:0];
                  m_lane = reg_wdata[11:8];
                  m_rate = reg_wdata[12];
                  m_req  = reg_wdata[16];
                end
          2'd2: clr = reg_wdata[1];
          default: ;
        endcase
      end
      if (tmo) m_err = 1; else if (clr) m_err = 0;
      if (!pend) m_cnt = 0; else if (!tmo) m_cnt = m_cnt + 1;
      ack_pipe.push_front(phy_ack_i);   ack_pipe.pop_back();
      rdy_pipe.push_front(phy_ready_i); rdy_pipe.pop_back();
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(phy_req_o === m_req[0], "R4 request level", phy_req_o, m_req);
    chk({phy_rate_o, phy_lane_o, phy_addr_o} === {m_rate[0], m_lane[3:0], m_addr[7:0]},
        "R2 PHY field outputs", {phy_rate_o, phy_lane_o, phy_addr_o},
        {m_rate[0], m_lane[3:0], m_addr[7:0]});
    chk(phy_wdata_o === m_data, "R3 payload output", phy_wdata_o, m_data);
    case (reg_raddr)
      2'd0: chk(reg_rdata === m_read(2'd0), "R3 data readback", reg_rdata, m_read(2'd0));
      2'd1: chk(reg_rdata === m_read(2'd1), "R5 command readback", reg_rdata, m_read(2'd1));
      2'd2: chk(reg_rdata === m_read(2'd2), "R7 status readback", reg_rdata, m_read(2'd2));
      default: chk(reg_rdata === 32'd0, "R9 unmapped readback", reg_rdata, 32'd0);
    endcase
  endtask

  // ---------------- PHY responder ----------------
  int  phy_dly = 2;
  bit  phy_mute = 1'b0;
  int  phy_cnt = 0;

  task automatic phy_update();
    if (phy_req_o !== phy_ack_i && !phy_mute) begin
      if (phy_cnt >= phy_dly) begin phy_ack_i = phy_req_o; phy_cnt = 0; end
      else phy_cnt++;
    end else begin
      phy_cnt = 0;
    end
  endtask

  // one clock: edge, settle, compare, respond
  task automatic step();
    @(posedge clk);
    #2;
    if (!done) compare_all();
    phy_update();
  endtask

  task automatic wr(input logic [1:0] ofs, input logic [31:0] val);
    reg_we = 1'b1; reg_waddr = ofs; reg_wdata = val;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] ofs, input logic [31:0] exp, input string tag);
    reg_raddr = ofs;
    #1;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_ack(input logic lvl, input string tag);
    bit seen;
    seen = 1'b0;
    reg_raddr = 2'd1;
    for (int i = 0; i < 100 && !seen; i++) begin
      step();
      if (reg_rdata[24] === lvl) seen = 1'b1;
    end
    chk(seen, tag, {31'd0, seen}, 32'd1);
  endtask

  task automatic full_write(input logic [7:0] a, input logic [3:0] l, input logic r,
                            input logic [31:0] d);
    logic [31:0] word;
    word = 32'h0001_0000 | {19'd0, r, l, a};
    wr(2'd0, d);
    wr(2'd1, word);
    chk(phy_req_o === 1'b1, "R4 request raised after issue", phy_req_o, 1);
    chk({phy_addr_o, phy_lane_o, phy_rate_o} === {a, l, r}, "R2 fields after issue",
        {phy_addr_o, phy_lane_o, phy_rate_o}, {a, l, r});
    wait_ack(1'b1, "R5 ack set after raised request");
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    chk(phy_req_o === 1'b0, "R4 request dropped after clear", phy_req_o, 0);
    wait_ack(1'b0, "R5 ack cleared after dropped request");
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd_check(2'd0, 32'd0, "R1 data after reset");
    rd_check(2'd1, 32'd0, "R1 command after reset");
    rd_check(2'd2, 32'd0, "R1 status after reset");
    rd_check(2'd3, 32'd0, "R1 unmapped after reset");
    chk({phy_req_o, phy_rate_o, phy_lane_o, phy_addr_o} === 14'd0, "R1 PHY outputs after reset",
        {phy_req_o, phy_rate_o, phy_lane_o, phy_addr_o}, 0);
    chk(phy_wdata_o === 32'd0, "R1 payload after reset", phy_wdata_o, 0);
    step();

    // R3 data register
    wr(2'd0, 32'hA5A5_1234);
    rd_check(2'd0, 32'hA5A5_1234, "R3 data readback");
    chk(phy_wdata_o === 32'hA5A5_1234, "R3 payload drive", phy_wdata_o, 32'hA5A5_1234);

    // R2 / R4 / R6 issue then write during pending phase
    phy_dly = 4;
    wr(2'd1, 32'h0001_1142);
    chk(phy_req_o === 1'b1, "R4 request rises", phy_req_o, 1);
    rd_check(2'd1, 32'h0001_1142, "R2 command readback while pending");
    wr(2'd1, 32'h0000_0E77);
    chk({phy_addr_o, phy_lane_o, phy_rate_o, phy_req_o} === {8'h42, 4'h1, 1'b1, 1'b1},
        "R6 pending write ignored", {phy_addr_o, phy_lane_o, phy_rate_o, phy_req_o},
        {8'h42, 4'h1, 1'b1, 1'b1});
    wait_ack(1'b1, "R5 ack set");
    chk(phy_req_o === 1'b1, "R5 request held with ack set", phy_req_o, 1);
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd0);
    chk(phy_req_o === 1'b0, "R4 request falls", phy_req_o, 0);
    wait_ack(1'b0, "R5 ack cleared");

    // several patterns with varied PHY latency
    for (int k = 0; k < 6; k++) begin
      phy_dly = k;
      full_write(8'h40 + 8'(k * 7), 4'(k + 3), k[0], 32'h1000_0000 + 32'(k * 32'h0101_0101));
    end

    // R7 timeout
    phy_mute = 1'b1;
    wr(2'd1, 32'h0001_0066);
    repeat (TMO + 4) step();
    rd_check(2'd2, 32'h2, "R7 timeout flag set");
    wr(2'd2, 32'h0);
    rd_check(2'd2, 32'h2, "R7 zero write keeps flag");
    wr(2'd2, 32'h2);
    rd_check(2'd2, 32'h2, "R7 new timeout wins over clear");
    phy_mute = 1'b0;
    phy_dly = 1;
    wait_ack(1'b1, "R5 late ack after stall");
    wr(2'd2, 32'h2);
    rd_check(2'd2, 32'h0, "R7 flag cleared by one");
    wr(2'd1, 32'd0);
    wait_ack(1'b0, "R5 ack cleared after stall");

    // R8 ready
    phy_ready_i = 1'b1;
    reg_raddr = 2'd2;
    step();
    chk(reg_rdata[0] === 1'b0, "R8 ready not yet through synchroniser", reg_rdata[0], 0);
    step();
    chk(reg_rdata[0] === 1'b1, "R8 ready visible", reg_rdata[0], 1);

    // R9 unmapped offset
    wr(2'd3, 32'hFFFF_FFFF);
    rd_check(2'd3, 32'd0, "R9 unmapped reads zero");
    rd_check(2'd0, 32'd0, "R9 data unchanged");
    rd_check(2'd1, 32'd0, "R9 command unchanged");
    chk(phy_req_o === 1'b0, "R9 request unchanged", phy_req_o, 0);
    repeat (4) step();

    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule